// File: doc/BRIEF.md
# Legacy Interrupt Line Aggregator

This block collects up to four level-sensitive legacy interrupt lines from an expansion bus and folds them into one interrupt towards a parent controller. Each line has a pending bit and an enable bit, and both sit in the upper halfword of a single 32-bit control word. The same word also carries a few error-mask and request-priority bits. The block keeps these only as plain storage so that software sees one coherent register.

An incoming line passes through a synchroniser and then sets its pending bit. Software reads the word to find the pending lines. It acknowledges a line by writing one to that line's pending bit. A line that is still asserted sets its pending bit again, because the lines are level-sensitive. A set enable bit lets the line reach the cascaded output, and that output is registered. The register port is a plain write strobe with two halfword enables and a read bus that always shows the current contents.

Top module: `intx_ctl`

## Requirements
- R1: After reset every pending bit, enable bit and stored bit is zero, `rd_data` reads 0 and `irq_out` is low.
- R2: Pending bit i sits at `rd_data[28+i]`. It becomes 1 at the third rising edge after line i is first driven high (two synchroniser flops, then the pending flop). It stays 0 before that edge.
- R3: A write with `wr_hw[1]` set clears pending bit i when `wr_data[28+i]` is 1. A 0 in that position leaves the bit unchanged. A pending bit holds its value until it is acknowledged.
- R4: If the synchronised line is still high, its pending bit is set again. A set and an acknowledge in the same cycle leave the bit at 1.
- R5: Enable bit i sits at bit 22+i. It is loaded from `wr_data[22+i]` by any write with `wr_hw[1]` set, and a 1 lets the line interrupt.
- R6: `irq_out` equals, one clock later, the OR over i of (pending i AND enable i).
- R7: Writing 0xF000 to the upper halfword (`wr_hw`=2'b10, `wr_data`=32'hF000_0000) clears all four pending bits, all four enables and the error-mask bits in one access. The priority bits are left as they were.
- R8: Bits 27:26 and 21:16 are read/write storage written under `wr_hw[1]`. Bits 14:8 are read/write storage written under `wr_hw[0]`. A halfword whose enable is clear is not changed.
- R9: Bits 15 and 7:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Level interrupt lines, bit i = line i (A..D) |
| wr_en | input | 1 | Register write strobe |
| wr_hw | input | 2 | Halfword enables: bit 1 = bits 31:16, bit 0 = bits 15:0 |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| irq_out | output | 1 | Registered cascaded interrupt |

## Verification
The bench builds the block with its default parameters: four lines, a two-flop synchroniser and a registered output. With four lines, every pending and enable position in the word is live, so the bulk clear and the halfword gating touch the whole upper field. The two-flop depth makes the three-edge set latency an exact cycle count that the directed part can test. A cycle-accurate reference model then follows thousands of random writes and line toggles. These include acknowledges that coincide with a set and writes that select only one halfword.

// File: rtl/intx_pkg.sv
package intx_pkg;
   localparam int REG_W     = 32;
   localparam int MAX_LINES = 4;
   // line field positions (software decodes these)
   localparam int STAT_LSB  = 28;
   localparam int EN_LSB    = 22;
   // plain storage fields
   localparam int ERRH_LSB  = 26;
   localparam int ERRH_W    = 2;
   localparam int ERRL_LSB  = 16;
   localparam int ERRL_W    = 6;
   localparam int PRI_LSB   = 8;
   localparam int PRI_W     = 7;

   typedef struct packed {
      logic [ERRH_W-1:0] err_hi;
      logic [ERRL_W-1:0] err_lo;
      logic [PRI_W-1:0]  prio;
   } cfg_store_t;
endpackage

// File: rtl/intx_sync.sv
module intx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   initial begin
      assert (STAGES >= 2) else $error("intx_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("intx_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_in;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/intx_pend.sv
module intx_pend #(
   parameter int NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lvl,
   input  logic                 hi_we,
   input  logic [NUM_LINES-1:0] ack_bits,
   input  logic [NUM_LINES-1:0] en_bits,
   output logic [NUM_LINES-1:0] pend,
   output logic [NUM_LINES-1:0] enable
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic ack_i;
      assign ack_i = hi_we & ack_bits[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i]   <= 1'b0;
            enable[i] <= 1'b0;
         end else begin
            pend[i] <= (pend[i] & ~ack_i) | lvl[i];
            if (hi_we) enable[i] <= en_bits[i];
         end
      end

      // R3
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i && !lvl[i]) |=> !pend[i]);
      // R3
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ack_i && !lvl[i]) |=> pend[i] == $past(pend[i]));
      // R4
      level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lvl[i] |=> pend[i]);
      // R5
      en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hi_we |=> enable[i] == $past(en_bits[i]));
      // R5
      en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !hi_we |=> $stable(enable[i]));
   end
endmodule

// File: rtl/intx_cfgstore.sv
module intx_cfgstore
   import intx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_we,
   input  logic             lo_we,
   input  logic [REG_W-1:0] wdata,
   output cfg_store_t       cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else begin
         if (hi_we) begin
            cfg.err_hi <= wdata[ERRH_LSB +: ERRH_W];
            cfg.err_lo <= wdata[ERRL_LSB +: ERRL_W];
         end
         if (lo_we) cfg.prio <= wdata[PRI_LSB +: PRI_W];
      end
   end

   // R8
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_we |=> ($stable(cfg.err_hi) && $stable(cfg.err_lo)));
   // R8
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_we |=> $stable(cfg.prio));
   // R8
   lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> cfg.prio == $past(wdata[PRI_LSB +: PRI_W]));
endmodule

// File: rtl/intx_ctl.sv
module intx_ctl
   import intx_pkg::*;
#(
   parameter int NUM_LINES   = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 wr_en,
   input  logic [1:0]           wr_hw,
   input  logic [31:0]          wr_data,
   output logic [31:0]          rd_data,
   output logic                 irq_out
);
   initial begin
      assert (NUM_LINES >= 1 && NUM_LINES <= MAX_LINES)
         else $error("intx_ctl: NUM_LINES out of range");
   end

   logic                 hi_we, lo_we;
   logic [NUM_LINES-1:0] lvl_s, pend, enable;
   logic                 any_hit;
   cfg_store_t           cfg;

   assign hi_we = wr_en & wr_hw[1];
   assign lo_we = wr_en & wr_hw[0];

   intx_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(irq_lines), .q_out(lvl_s));

   intx_pend #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .hi_we(hi_we),
      .ack_bits(wr_data[STAT_LSB +: NUM_LINES]),
      .en_bits(wr_data[EN_LSB +: NUM_LINES]),
      .pend(pend), .enable(enable));

   intx_cfgstore u_cfg (
      .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we),
      .wdata(wr_data), .cfg(cfg));

   always_comb begin
      rd_data = '0;
      rd_data[STAT_LSB +: NUM_LINES] = pend;
      rd_data[EN_LSB +: NUM_LINES]   = enable;
      rd_data[ERRH_LSB +: ERRH_W]    = cfg.err_hi;
      rd_data[ERRL_LSB +: ERRL_W]    = cfg.err_lo;
      rd_data[PRI_LSB +: PRI_W]      = cfg.prio;
   end

   assign any_hit = |(pend & enable);

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= any_hit;
      end
      // R6
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq_out == $past(|(u_pend.pend & u_pend.enable)));
   end else begin : g_ocomb
      assign irq_out = any_hit;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|u_pend.enable));
endmodule

// File: tb/sim_intx_ctl.sv
module sim_intx_ctl;
   localparam int SYNC = 2;
   localparam logic [31:0] HI_M = 32'h0C3F_0000;
   localparam logic [31:0] LO_M = 32'h0000_7F00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  lines = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_hw = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_out;

   int checks = 0;
   int errs = 0;
   bit done = 0;

   logic [3:0]  m_s [SYNC];
   logic [3:0]  m_stat = '0, m_en = '0;
   logic [31:0] m_cfg = '0;
   logic        m_irq = 1'b0;

   always #4 clk = ~clk;

   intx_ctl u0 (.clk(clk), .rst_n(rst_n), .irq_lines(lines), .wr_en(wr_en),
                .wr_hw(wr_hw), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd();
      logic [31:0] e;
      e = m_cfg;
      e[31:28] = m_stat;
      e[25:22] = m_en;
      return e;
   endfunction

   task automatic step(input logic [3:0] ln, input logic we,
                       input logic [1:0] hw, input logic [31:0] wd);
      logic whi, wlo;
      logic [3:0] n_stat, n_en;
      logic [31:0] msk, n_cfg;
      logic n_irq;
      lines = ln; wr_en = we; wr_hw = hw; wr_data = wd;
      whi = we & hw[1];
      wlo = we & hw[0];
      n_stat = (m_stat & ~(whi ? wd[31:28] : 4'h0)) | m_s[SYNC-1];
      n_en   = whi ? wd[25:22] : m_en;
      msk    = (whi ? HI_M : 32'h0) | (wlo ? LO_M : 32'h0);
      n_cfg  = (m_cfg & ~msk) | (wd & msk);
      n_irq  = |(m_stat & m_en);
      @(posedge clk);
      for (int k = SYNC-1; k > 0; k--) m_s[k] = m_s[k-1];
      m_s[0] = ln;
      m_stat = n_stat; m_en = n_en; m_cfg = n_cfg; m_irq = n_irq;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmp_model();
      chk({28'h0, rd_data[31:28]}, {28'h0, m_stat}, "R2/R3/R4 pending field");
      chk({28'h0, rd_data[25:22]}, {28'h0, m_en}, "R5 enable field");
      chk(rd_data & (HI_M | LO_M), m_cfg, "R8 stored fields");
      chk({24'h0, rd_data[15], rd_data[7:0]} & 32'h1FF, 32'h0, "R9 reserved bits");
      chk({31'h0, irq_out}, {31'h0, m_irq}, "R6 cascaded output");
   endtask

   initial begin
      for (int k = 0; k < SYNC; k++) m_s[k] = '0;
      repeat (3) @(negedge clk);
      chk(rd_data, 32'h0, "R1 read after reset");
      chk({31'h0, irq_out}, 32'h0, "R1 irq after reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data, 32'h0, "R1 read after release");

      // line 2 high, masked
      step(4'b0100, 0, 2'b00, 0);
      step(4'b0100, 0, 2'b00, 0);
      chk({31'h0, rd_data[30]}, 32'h0, "R2 not set before third edge");
      step(4'b0100, 0, 2'b00, 0);
      chk({31'h0, rd_data[30]}, 32'h1, "R2 set at third edge");
      step(4'b0100, 0, 2'b00, 0);
      chk({31'h0, irq_out}, 32'h0, "R6 masked line gives no irq");
      // enable line 2
      step(4'b0100, 1, 2'b10, 32'h0100_0000);
      chk({31'h0, rd_data[24]}, 32'h1, "R5 enable bit loaded");
      step(4'b0100, 0, 2'b00, 0);
      chk({31'h0, irq_out}, 32'h1, "R6 enabled pending raises irq");
      // ack while still high
      step(4'b0100, 1, 2'b10, 32'h4100_0000);
      chk({31'h0, rd_data[30]}, 32'h1, "R4 ack while line high keeps pending");
      // drop line, pending holds
      repeat (4) step(4'b0000, 0, 2'b00, 0);
      chk({31'h0, rd_data[30]}, 32'h1, "R3 pending held until ack");
      step(4'b0000, 1, 2'b10, 32'h0100_0000);
      chk({31'h0, rd_data[30]}, 32'h1, "R3 zero write leaves pending");
      step(4'b0000, 1, 2'b10, 32'h4100_0000);
      chk({31'h0, rd_data[30]}, 32'h0, "R3 one write clears pending");
      step(4'b0000, 0, 2'b00, 0);
      chk({31'h0, irq_out}, 32'h0, "R6 irq drops after ack");
      // halfword gating
      step(4'b0000, 1, 2'b01, 32'hFFFF_FFFF);
      chk(rd_data, 32'h0100_7F00, "R8 low halfword only, R9 reserved zero");
      step(4'b0000, 1, 2'b10, 32'hFFFF_FFFF);
      chk(rd_data, 32'h0FFF_7F00, "R8 upper halfword storage, R9 reserved zero");
      // bulk clear
      repeat (4) step(4'b1111, 0, 2'b00, 0);
      repeat (3) step(4'b0000, 0, 2'b00, 0);
      chk({28'h0, rd_data[31:28]}, 32'hF, "R2 all four pending");
      step(4'b0000, 1, 2'b10, 32'hF000_0000);
      chk(rd_data, 32'h0000_7F00, "R7 bulk clear of pending, enables, masks");
      step(4'b0000, 0, 2'b00, 0);
      chk({31'h0, irq_out}, 32'h0, "R7 irq low after bulk clear");

      // random phase against the model
      begin
         int unsigned sd;
         logic [3:0] ln;
         sd = $urandom(32'd2024);
         ln = '0;
         for (int n = 0; n < 3000; n++) begin
            logic we;
            if ($urandom_range(0, 7) == 0) ln = 4'($urandom);
            we = ($urandom_range(0, 3) == 0);
            step(ln, we, 2'($urandom), $urandom);
            cmp_model();
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule